// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a variable-length instruction decoder. It walks the leading bytes of one instruction, one byte per cycle through a valid/ready handshake. It stops at the first byte that is not part of the prefix area and then reports a compact prefix record. The caller sets `mode` to give the code-segment width: 0 selects 16-bit, 1 selects 32-bit, 2 selects 64-bit, and 3 behaves as 32-bit.

Along with the current byte, the caller presents the byte that follows it on `in_next`. The two-byte and three-byte vector escapes (C4, C5 and 8F) are only escapes under a test that reads the following byte, and this lookahead lets the scanner decide before it takes the escape byte. A one-cycle `start` pulse begins each instruction and returns the record to the defaults for the current mode.

The scanner does not accept the byte that ends the scan. When the scan ends, `done` pulses once and `byte_count` gives the number of bytes taken, which is the offset of the opcode byte. Opcode lookup and operand parsing happen downstream.

Top module: `pfx_scan`

## Requirements
- R1: Byte F2 sets `rep` to 1 and F3 sets it to 2. Byte 9B sets `wait_flag` and F0 sets `lock`. When a prefix class appears more than once, the last byte of that class wins.
- R2: The segment override bytes set `seg` as follows: 26 gives 1 (ES), 2E gives 2 (CS), 36 gives 3 (SS), 3E gives 4 (DS), 64 gives 5 (FS) and 65 gives 6 (GS). The last override seen wins, and 0 means no override.
- R3: Size codes are 0 for 16, 1 for 32 and 2 for 64. By default `asize` equals the segment width. `osize` also equals the segment width, except in 64-bit mode, where it is 32.
- R4: Byte 66 sets `osize` to 32 in 16-bit mode and to 16 in every other mode. Byte 67 sets `asize` to 16 in 32-bit mode and to 32 in every other mode.
- R5: In 64-bit mode, a byte 40..4F is taken and ends the scan. Its bits 2, 1, 0 and 3 go to `rex_r`, `rex_x`, `rex_b` and `rex_w`, and a set bit 3 forces `osize` to 64. In any other mode, such a byte ends the scan and is not taken.
- R6: C4 and C5 are escapes only in 64-bit mode, or when bits 7:6 of the following byte are both 1. In any other case they end the scan as opcodes and are not taken.
- R7: In the three-byte escape, the first payload byte gives `rex_r`, `rex_x` and `rex_b` as the inverse of its bits 7, 6 and 5, and gives `opmap` from its bits 4:0. The second payload byte gives `rex_w` from bit 7, `vreg` as the inverse of bits 6:3, `vlen` from bit 2 and `pp` from bits 1:0.
- R8: In the two-byte escape, the single payload byte gives `rex_r` as the inverse of bit 7, `vreg` as the inverse of bits 6:3, `vlen` from bit 2 and `pp` from bits 1:0. `opmap` is set to 1 and `rex_w` stays 0.
- R9: 8F is an escape only when bits 4:3 of the next byte are not both 0 and the R6 condition also holds. It uses the R7 layout. `esc` reports 1 for the two-byte form, 2 for the C4 form, 3 for the 8F form and 0 for none. The scan ends right after the last payload byte.
- R10: Any other byte ends the scan with `in_ready` low. `done` pulses one cycle after the edge at which the scan ends. `byte_count` advances by one for each accepted byte and equals the opcode offset at `done`.
- R11: If the count reaches 15 while the scan would continue, the scan stops without `done`. `err` is raised and held until the next `start`, and `byte_count` reads 15.
- R12: Reset or `start` clears the count, `done` and `err`, and returns every record field to the R3 defaults and zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Segment width: 0=16, 1=32, 2=64, 3 treated as 32 |
| start | input | 1 | New-instruction pulse; clears the record and starts a scan |
| in_valid | input | 1 | Current byte present |
| in_data | input | 8 | Current byte |
| in_next | input | 8 | Byte after the current one (lookahead) |
| in_ready | output | 1 | Current byte accepted at this edge |
| done | output | 1 | One-cycle pulse: scan finished at an opcode |
| err | output | 1 | Prefix area too long (sticky until start) |
| byte_count | output | 4 | Bytes accepted so far |
| osize | output | 2 | Effective operand size code |
| asize | output | 2 | Effective address size code |
| rep | output | 2 | 0 none, 1 from F2, 2 from F3 |
| lock | output | 1 | Lock byte seen |
| wait_flag | output | 1 | Wait byte seen |
| seg | output | 3 | Segment override code |
| rex_r | output | 1 | Register-field extension |
| rex_x | output | 1 | Index extension |
| rex_b | output | 1 | Base extension |
| rex_w | output | 1 | Wide-operand bit |
| esc | output | 2 | Escape form code |
| opmap | output | 5 | Opcode map from the escape |
| vreg | output | 4 | Extra source register from the escape |
| vlen | output | 1 | Vector length bit |
| pp | output | 2 | Implied-prefix field |

## Verification
Directed streams target each decision the scanner makes from the lookahead byte. They include C5, C4 and 8F followed by bytes that do and do not qualify, in 16-bit and 64-bit modes. This separates the "take as escape" path from the "end as opcode" path. Further directed streams cover repeated prefixes of one class, 66/67 in each mode, and REX bytes with W set both inside and outside 64-bit mode. Together they distinguish last-wins behaviour, the size flips and REX acceptance. Length corner cases follow: 14 prefixes then an opcode, 15 prefixes, and an escape that would cross the limit. These tell a completed scan from an aborted one at the exact boundary. Random streams then mix every prefix class with random escape payloads in all modes, and each stream is compared field by field against a bench model.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2} sz_e;

  typedef enum logic [2:0] {
    BC_OPC  = 3'd0,
    BC_LEG  = 3'd1,
    BC_REX  = 3'd2,
    BC_VEX2 = 3'd3,
    BC_VEX3 = 3'd4,
    BC_XOP  = 3'd5
  } bcls_e;

  typedef enum logic [1:0] {
    ESC_NONE = 2'd0,
    ESC_VEX2 = 2'd1,
    ESC_VEX3 = 2'd2,
    ESC_XOP  = 2'd3
  } esc_e;

  typedef struct packed {
    sz_e        osz;
    sz_e        asz;
    logic [1:0] rep;
    logic       lock;
    logic       wt;
    logic [2:0] seg;
    logic       rx;
    logic       xx;
    logic       bx;
    logic       wx;
    esc_e       esc;
    logic [4:0] map;
    logic [3:0] vvvv;
    logic       vl;
    logic [1:0] pp;
  } rec_t;

  function automatic logic is_long(input logic [1:0] mode);
    return mode == 2'd2;
  endfunction

  function automatic sz_e base_asz(input logic [1:0] mode);
    case (mode)
      2'd0:    return SZ16;
      2'd2:    return SZ64;
      default: return SZ32;
    endcase
  endfunction

  function automatic sz_e base_osz(input logic [1:0] mode);
    return (mode == 2'd0) ? SZ16 : SZ32;
  endfunction

  // operand-size override: flips toward the non-native width
  function automatic sz_e osz_flip(input logic [1:0] mode);
    return (mode == 2'd0) ? SZ32 : SZ16;
  endfunction

  // address-size override: 16 only from a 32-bit segment
  function automatic sz_e asz_flip(input logic [1:0] mode);
    return (mode == 2'd1 || mode == 2'd3) ? SZ16 : SZ32;
  endfunction

  // escape bytes qualify in long mode or when the lookahead top bits are 11
  function automatic logic esc_window(input logic [1:0] mode, input logic [7:0] nx);
    return is_long(mode) || (nx[7:6] == 2'b11);
  endfunction

  function automatic logic is_legacy(input logic [7:0] b);
    case (b)
      8'hF2, 8'hF3, 8'h9B, 8'hF0,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic bcls_e classify(input logic [1:0] mode, input logic [7:0] b,
                                     input logic [7:0] nx);
    bcls_e c;
    c = BC_OPC;
    if (is_legacy(b))                                          c = BC_LEG;
    else if (b[7:4] == 4'h4 && is_long(mode))                  c = BC_REX;
    else if (b == 8'hC4 && esc_window(mode, nx))               c = BC_VEX3;
    else if (b == 8'hC5 && esc_window(mode, nx))               c = BC_VEX2;
    else if (b == 8'h8F && nx[4:3] != 2'b00 && esc_window(mode, nx)) c = BC_XOP;
    return c;
  endfunction

  function automatic rec_t rec_init(input logic [1:0] mode);
    rec_t r;
    r     = '0;
    r.osz = base_osz(mode);
    r.asz = base_asz(mode);
    r.esc = ESC_NONE;
    return r;
  endfunction

  function automatic rec_t apply_legacy(input rec_t r, input logic [1:0] mode,
                                        input logic [7:0] b);
    rec_t o;
    o = r;
    case (b)
      8'hF2:   o.rep  = 2'd1;
      8'hF3:   o.rep  = 2'd2;
      8'h9B:   o.wt   = 1'b1;
      8'hF0:   o.lock = 1'b1;
      8'h26:   o.seg  = 3'd1;
      8'h2E:   o.seg  = 3'd2;
      8'h36:   o.seg  = 3'd3;
      8'h3E:   o.seg  = 3'd4;
      8'h64:   o.seg  = 3'd5;
      8'h65:   o.seg  = 3'd6;
      8'h66:   o.osz  = osz_flip(mode);
      8'h67:   o.asz  = asz_flip(mode);
      default: ;
    endcase
    return o;
  endfunction

  function automatic rec_t apply_rex(input rec_t r, input logic [7:0] b);
    rec_t o;
    o    = r;
    o.rx = b[2];
    o.xx = b[1];
    o.bx = b[0];
    o.wx = b[3];
    if (b[3]) o.osz = SZ64;
    return o;
  endfunction

  function automatic rec_t apply_pay1(input rec_t r, input logic [7:0] b);
    rec_t o;
    o    = r;
    o.rx = ~b[7];
    if (r.esc == ESC_VEX2) begin
      o.map  = 5'd1;
      o.vvvv = ~b[6:3];
      o.vl   = b[2];
      o.pp   = b[1:0];
    end else begin
      o.xx  = ~b[6];
      o.bx  = ~b[5];
      o.map = b[4:0];
    end
    return o;
  endfunction

  function automatic rec_t apply_pay2(input rec_t r, input logic [7:0] b);
    rec_t o;
    o      = r;
    o.wx   = b[7];
    o.vvvv = ~b[6:3];
    o.vl   = b[2];
    o.pp   = b[1:0];
    return o;
  endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [7:0] byte_i,
  input  logic [7:0] next_i,
  output bcls_e      cls
);

  always_comb cls = classify(mode, byte_i, next_i);

endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
  import pfx_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_valid,
  input  bcls_e         cls,
  output logic          in_ready,
  output logic          tk_leg,
  output logic          tk_rex,
  output logic          tk_esc,
  output logic          tk_p1,
  output logic          tk_p2,
  output logic          finish,
  output logic          overrun,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] count
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_PAY1, S_PAY2} st_e;

  st_e           st_q;
  logic          short_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          done_q;
  logic          err_q;
  logic          scan;
  logic          fire;
  logic          stop_opc;

  always_comb begin
    scan     = (st_q == S_SCAN);
    busy     = (st_q != S_IDLE);
    in_ready = (scan && cls != BC_OPC) || st_q == S_PAY1 || st_q == S_PAY2;
    fire     = in_valid && in_ready;
    tk_leg   = fire && scan && cls == BC_LEG;
    tk_rex   = fire && scan && cls == BC_REX;
    tk_esc   = fire && scan && (cls == BC_VEX2 || cls == BC_VEX3 || cls == BC_XOP);
    tk_p1    = fire && st_q == S_PAY1;
    tk_p2    = fire && st_q == S_PAY2;
    stop_opc = scan && in_valid && cls == BC_OPC;
    finish   = stop_opc || tk_rex || (tk_p1 && short_q) || tk_p2;
    cnt_nx   = cnt_q + 1'b1;
    overrun  = fire && !finish && (cnt_nx >= CW'(MAX_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      short_q <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (start) begin
      st_q    <= S_SCAN;
      short_q <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= finish;
      err_q  <= err_q | overrun;
      if (fire)   cnt_q   <= cnt_nx;
      if (tk_esc) short_q <= (cls == BC_VEX2);
      if (finish || overrun) st_q <= S_IDLE;
      else if (tk_esc)       st_q <= S_PAY1;
      else if (tk_p1)        st_q <= S_PAY2;
    end
  end

  assign done  = done_q;
  assign err   = err_q;
  assign count = cnt_q;

endmodule

// File: rtl/pfx_record.sv
module pfx_record
  import pfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic [7:0] byte_i,
  input  bcls_e      cls,
  input  logic       tk_leg,
  input  logic       tk_rex,
  input  logic       tk_esc,
  input  logic       tk_p1,
  input  logic       tk_p2,
  output rec_t       rec
);

  rec_t rec_q;
  rec_t rec_d;

  always_comb begin
    rec_d = rec_q;
    if (tk_leg) rec_d = apply_legacy(rec_q, mode, byte_i);
    if (tk_rex) rec_d = apply_rex(rec_q, byte_i);
    if (tk_esc) begin
      case (cls)
        BC_VEX2: rec_d.esc = ESC_VEX2;
        BC_VEX3: rec_d.esc = ESC_VEX3;
        default: rec_d.esc = ESC_XOP;
      endcase
    end
    if (tk_p1) rec_d = apply_pay1(rec_q, byte_i);
    if (tk_p2) rec_d = apply_pay2(rec_q, byte_i);
  end

  always_ff @(posedge clk) begin
    if (rst || start) rec_q <= rec_init(mode);
    else              rec_q <= rec_d;
  end

  assign rec = rec_q;

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
  import pfx_pkg::*;
#(
  parameter  int MAX_LEN = 15,
  localparam int CW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          start,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic [7:0]    in_next,
  output logic          in_ready,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] byte_count,
  output logic [1:0]    osize,
  output logic [1:0]    asize,
  output logic [1:0]    rep,
  output logic          lock,
  output logic          wait_flag,
  output logic [2:0]    seg,
  output logic          rex_r,
  output logic          rex_x,
  output logic          rex_b,
  output logic          rex_w,
  output logic [1:0]    esc,
  output logic [4:0]    opmap,
  output logic [3:0]    vreg,
  output logic          vlen,
  output logic [1:0]    pp
);

  bcls_e cls;
  rec_t  rec;
  logic  tk_leg, tk_rex, tk_esc, tk_p1, tk_p2;
  logic  scan_finish, scan_overrun, scan_busy;

  pfx_classify u_cls (
    .mode   (mode),
    .byte_i (in_data),
    .next_i (in_next),
    .cls    (cls)
  );

  pfx_ctrl #(.MAX_LEN(MAX_LEN), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .cls      (cls),
    .in_ready (in_ready),
    .tk_leg   (tk_leg),
    .tk_rex   (tk_rex),
    .tk_esc   (tk_esc),
    .tk_p1    (tk_p1),
    .tk_p2    (tk_p2),
    .finish   (scan_finish),
    .overrun  (scan_overrun),
    .busy     (scan_busy),
    .done     (done),
    .err      (err),
    .count    (byte_count)
  );

  pfx_record u_rec (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode   (mode),
    .byte_i (in_data),
    .cls    (cls),
    .tk_leg (tk_leg),
    .tk_rex (tk_rex),
    .tk_esc (tk_esc),
    .tk_p1  (tk_p1),
    .tk_p2  (tk_p2),
    .rec    (rec)
  );

  assign osize     = rec.osz;
  assign asize     = rec.asz;
  assign rep       = rec.rep;
  assign lock      = rec.lock;
  assign wait_flag = rec.wt;
  assign seg       = rec.seg;
  assign rex_r     = rec.rx;
  assign rex_x     = rec.xx;
  assign rex_b     = rec.bx;
  assign rex_w     = rec.wx;
  assign esc       = rec.esc;
  assign opmap     = rec.map;
  assign vreg      = rec.vvvv;
  assign vlen      = rec.vl;
  assign pp        = rec.pp;

endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
  parameter  int MAX_LEN = 15,
  localparam int CW      = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    in_data,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] byte_count,
  input logic [1:0]    osize,
  input logic          tk_rex,
  input logic          scan_finish,
  input logic          scan_overrun,
  input logic          scan_busy
);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !start) |=> byte_count == $past(byte_count) + 1'b1);

  // R10
  finish_done_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_finish && !start) |=> (done && !scan_busy));

  // R11
  err_len_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> byte_count == CW'(MAX_LEN));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> err);

  // R11
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_overrun && !start) |=> (err && !done));

  // R5
  rex_w_chk: assert property (@(posedge clk) disable iff (rst)
    (tk_rex && in_data[3] && !start) |=> osize == 2'd2);

  // R12
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (byte_count == '0 && !err && !done && scan_busy));

endmodule

bind pfx_scan pfx_scan_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .done         (done),
  .err          (err),
  .byte_count   (byte_count),
  .osize        (osize),
  .tk_rex       (tk_rex),
  .scan_finish  (scan_finish),
  .scan_overrun (scan_overrun),
  .scan_busy    (scan_busy)
);

// File: tb/sim_pfx_scan.sv
module sim_pfx_scan;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic       start;
  logic       in_valid;
  logic [7:0] in_data;
  logic [7:0] in_next;
  logic       in_ready, done, err;
  logic [3:0] byte_count;
  logic [1:0] osize, asize, rep, esc, pp;
  logic       lock, wait_flag, rex_r, rex_x, rex_b, rex_w, vlen;
  logic [2:0] seg;
  logic [4:0] opmap;
  logic [3:0] vreg;

  always #4 clk = ~clk;

  pfx_scan u0 (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_next(in_next), .in_ready(in_ready), .done(done),
    .err(err), .byte_count(byte_count), .osize(osize), .asize(asize), .rep(rep),
    .lock(lock), .wait_flag(wait_flag), .seg(seg), .rex_r(rex_r), .rex_x(rex_x),
    .rex_b(rex_b), .rex_w(rex_w), .esc(esc), .opmap(opmap), .vreg(vreg),
    .vlen(vlen), .pp(pp)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] sb [0:31];

  int e_os, e_as, e_rep, e_lock, e_wt, e_seg, e_r, e_x, e_b, e_w;
  int e_esc, e_map, e_vv, e_l, e_pp, e_cnt, e_err;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int szcode(input int bits);
    return (bits == 16) ? 0 : (bits == 32) ? 1 : 2;
  endfunction

  task automatic clear_buf();
    for (int k = 0; k < 32; k++) sb[k] = 8'h90;
  endtask

  // Reference model: walks the buffer with the requirement rules
  task automatic model(input int m);
    int  i;
    bit  go;
    logic [7:0] b, nx, p;
    i = 0; go = 1;
    e_os  = (m == 0) ? 16 : 32;
    e_as  = (m == 2) ? 64 : (m == 0) ? 16 : 32;
    e_rep = 0; e_lock = 0; e_wt = 0; e_seg = 0;
    e_r = 0; e_x = 0; e_b = 0; e_w = 0;
    e_esc = 0; e_map = 0; e_vv = 0; e_l = 0; e_pp = 0; e_err = 0;
    while (go) begin
      bit leg;
      b = sb[i]; nx = sb[i+1]; leg = 1;
      case (b)
        8'hF2: e_rep = 1;
        8'hF3: e_rep = 2;
        8'h9B: e_wt = 1;
        8'hF0: e_lock = 1;
        8'h26: e_seg = 1;
        8'h2E: e_seg = 2;
        8'h36: e_seg = 3;
        8'h3E: e_seg = 4;
        8'h64: e_seg = 5;
        8'h65: e_seg = 6;
        8'h66: e_os = (m == 0) ? 32 : 16;
        8'h67: e_as = (m == 1 || m == 3) ? 16 : 32;
        default: leg = 0;
      endcase
      if (leg) begin
        i++;
        if (i == 15) begin e_err = 1; go = 0; end
      end else if (m == 2 && b >= 8'h40 && b <= 8'h4F) begin
        e_w = b[3]; e_r = b[2]; e_x = b[1]; e_b = b[0];
        if (e_w != 0) e_os = 64;
        i++; go = 0;
      end else if ((b == 8'hC4 || b == 8'hC5 || (b == 8'h8F && nx[4:3] != 0))
                   && (m == 2 || nx[7:6] == 2'b11)) begin
        e_esc = (b == 8'hC5) ? 1 : (b == 8'hC4) ? 2 : 3;
        i++;
        if (i >= 15) begin e_err = 1; go = 0; end
        else begin
          p = sb[i];
          e_r = p[7] ? 0 : 1;
          if (b == 8'hC5) begin
            e_map = 1; e_vv = 15 - p[6:3]; e_l = p[2]; e_pp = p[1:0];
            i++; go = 0;
          end else begin
            e_x = p[6] ? 0 : 1; e_b = p[5] ? 0 : 1; e_map = p[4:0];
            i++;
            if (i >= 15) begin e_err = 1; go = 0; end
            else begin
              p = sb[i];
              e_w = p[7]; e_vv = 15 - p[6:3]; e_l = p[2]; e_pp = p[1:0];
              i++; go = 0;
            end
          end
        end
      end else begin
        go = 0;
      end
    end
    e_cnt = i;
  endtask

  task automatic run(input int m, input string tag);
    int idx;
    int cyc;
    bit acc;
    idx = 0; cyc = 0;
    model(m);
    @(negedge clk);
    mode = m[1:0]; start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R12: record back at defaults after start
    chk({tag, " R12 cleared count"}, byte_count, 0);
    chk({tag, " R12 cleared osize"}, osize, (m == 0) ? 0 : 1);
    chk({tag, " R12 cleared flags"}, {rep, lock, wait_flag, seg, esc, err}, 0);
    forever begin
      if (done || err) break;
      if (cyc > 40) begin
        chk({tag, " R10 scan hung"}, 0, 1);
        break;
      end
      in_data = sb[idx]; in_next = sb[idx+1]; in_valid = 1'b1;
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) idx++;
      @(negedge clk);
      in_valid = 1'b0;
      cyc++;
    end
    chk({tag, " R10 count"}, byte_count, e_cnt);
    chk({tag, " R10 accepted bytes"}, idx, e_cnt);
    chk({tag, " R10 done"}, done, e_err ? 0 : 1);
    chk({tag, " R11 err"}, err, e_err);
    chk({tag, " R3 R4 osize"}, osize, szcode(e_os));
    chk({tag, " R3 R4 asize"}, asize, szcode(e_as));
    chk({tag, " R1 rep/lock/wait"}, {rep, lock, wait_flag}, {e_rep[1:0], e_lock[0], e_wt[0]});
    chk({tag, " R2 seg"}, seg, e_seg);
    chk({tag, " R5 R7 R8 rxbw"}, {rex_r, rex_x, rex_b, rex_w},
        {e_r[0], e_x[0], e_b[0], e_w[0]});
    chk({tag, " R9 esc"}, esc, e_esc);
    chk({tag, " R7 R8 map/vreg/l/pp"}, {opmap, vreg, vlen, pp},
        {e_map[4:0], e_vv[3:0], e_l[0], e_pp[1:0]});
  endtask

  function automatic logic [7:0] pick_legacy(input int k);
    case (k)
      0: return 8'hF2;  1: return 8'hF3;  2: return 8'h9B;  3: return 8'hF0;
      4: return 8'h26;  5: return 8'h2E;  6: return 8'h36;  7: return 8'h3E;
      8: return 8'h64;  9: return 8'h65; 10: return 8'h66;
      default: return 8'h67;
    endcase
  endfunction

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; mode = 2'd2; start = 1'b0; in_valid = 1'b0;
    in_data = 8'h00; in_next = 8'h00;
    clear_buf();
    repeat (3) @(negedge clk);
    // R3 / R12: reset state
    chk("R12 reset ready", in_ready, 0);
    chk("R12 reset done/err", {done, err}, 0);
    chk("R12 reset count", byte_count, 0);
    chk("R3 reset osize 64-bit mode", osize, 1);
    chk("R3 reset asize 64-bit mode", asize, 2);
    rst = 1'b0;

    // R4 size overrides in 16-bit mode
    clear_buf(); sb[0] = 8'h66; sb[1] = 8'h67;
    run(0, "d_size16");
    // R1 R2 repeats, R4 in 32-bit mode
    clear_buf(); sb[0] = 8'h66; sb[1] = 8'h67; sb[2] = 8'hF2; sb[3] = 8'hF3;
    sb[4] = 8'h2E; sb[5] = 8'h65; sb[6] = 8'h9B; sb[7] = 8'hF0;
    run(1, "d_repeat32");
    // R5 REX.W after 66 forces 64
    clear_buf(); sb[0] = 8'h66; sb[1] = 8'h4F;
    run(2, "d_rexw");
    // R5 REX byte outside long mode is an opcode
    clear_buf(); sb[0] = 8'h48;
    run(1, "d_rex32");
    // R6 C5 not qualifying / qualifying in 16-bit mode
    clear_buf(); sb[0] = 8'hC5; sb[1] = 8'h80;
    run(0, "d_c5_opc");
    clear_buf(); sb[0] = 8'hC5; sb[1] = 8'hF8;
    run(0, "d_c5_vex");
    // R7 three-byte form in long mode
    clear_buf(); sb[0] = 8'hC4; sb[1] = 8'hE2; sb[2] = 8'h7D;
    run(2, "d_c4");
    // R9 8F cases
    clear_buf(); sb[0] = 8'h8F; sb[1] = 8'h00;
    run(2, "d_8f_opc");
    clear_buf(); sb[0] = 8'h8F; sb[1] = 8'hE8; sb[2] = 8'h78;
    run(1, "d_8f_xop");
    // R11 length limits
    clear_buf(); for (int k = 0; k < 15; k++) sb[k] = 8'hF0;
    run(1, "d_len15");
    clear_buf(); for (int k = 0; k < 14; k++) sb[k] = 8'hF2;
    run(0, "d_len14");
    clear_buf(); for (int k = 0; k < 14; k++) sb[k] = 8'h3E;
    sb[14] = 8'hC4; sb[15] = 8'h01; sb[16] = 8'h02;
    run(2, "d_len_esc");

    // Random streams
    for (int t = 0; t < 300; t++) begin
      int m, n, kind, pos;
      clear_buf();
      m = $urandom_range(0, 2);
      n = $urandom_range(0, 6);
      pos = 0;
      for (int k = 0; k < n; k++) begin
        sb[pos] = pick_legacy($urandom_range(0, 11)); pos++;
      end
      kind = $urandom_range(0, 5);
      case (kind)
        1: begin sb[pos] = 8'h40 + 8'($urandom_range(0, 15)); pos++; end
        2: begin sb[pos] = 8'hC4; pos++; end
        3: begin sb[pos] = 8'hC5; pos++; end
        4: begin sb[pos] = 8'h8F; pos++; end
        default: ;
      endcase
      for (int k = pos; k < pos + 4; k++) sb[k] = 8'($urandom_range(0, 255));
      run(m, "rand");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule